// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a two-wire serial slave that exposes a bank of eight 8-bit configuration registers to a host controller on an SMBus-compatible bus. The host can write or read one addressed register, or move a run of registers in a single block transfer. A block transfer always starts at register 0 and carries a byte count. The clock and data lines arrive as plain inputs that are sampled by the core clock. The data line is pulled low through an output-enable pin, so the pad stays open drain.

The command byte that follows the write address selects the mode. Its top bit chooses between a single-byte access and a block access. The next two bits form a chip-select field that must be zero. The low five bits give the register offset. Two registers are partly or fully fixed. The second-to-last register shows, in its low nibble, four strap values captured from a parallel input while reset is held. The last register returns a constant identification byte of 18h. Every register value is also presented on a flat parallel output for the surrounding logic.

Top module: `smb_cfg_slave`

## Requirements
- R1: Only the address byte whose upper seven bits are 1101001 (D2h write, D3h read) is acknowledged. Any other address gets no acknowledge, and the rest of that transfer changes no register.
- R2: In the command byte, bit 7 = 1 selects a byte access with offset bits 4:0, and bit 7 = 0 selects a block access. The command is not acknowledged, and the rest of the transfer is ignored, in three cases: bits 6:5 are not 00; a block command has non-zero bits 4:0; or a byte offset is 8 or higher.
- R3: A byte write (D2h, command, data) acknowledges each byte and stores the data in the addressed register.
- R4: A byte read (D2h, command, repeated start, D3h) returns the addressed register, most significant bit first.
- R5: A block write (D2h, command 00h, count, data...) acknowledges the count and ignores its value. It stores the data bytes into registers 0, 1, 2 and up in order. A stop after any complete byte keeps the bytes already written.
- R6: Block-write data bytes beyond register 7 are acknowledged and discarded.
- R7: A block read returns the count 8 first, then registers 0 to 7 in order. Any byte past register 7 reads FFh.
- R8: After reset, registers 0 and 1 are FFh and registers 2 to 5 are 00h. Register 6 is {0000, strap}. Register 7 is 18h.
- R9: Register 7 is read only. Bits 3:0 of register 6 are read only and hold strap_i as it was while rst was high. Bits 7:4 of register 6 are writable.
- R10: After the host answers a read byte with no acknowledge, the slave releases the data line until the next start.
- R11: regs_o carries register k on bits 8k+7:8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the bus lines |
| rst | input | 1 | Synchronous active-high reset; also captures strap_i |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| strap_i | input | 4 | Strap values captured during reset |
| regs_o | output | 64 | All eight register values, register k at bits 8k+7:8k |

## Verification
The assertions assume the following about the host:
- Each clock-low and clock-high phase lasts longer than the three-flop sampling path.
- The host never issues a start or stop while the slave is pulling the data line.

Under these conditions, any change on sda_oe falls in a low phase of the raw clock. The bench host keeps within them in three ways:
- Every bus phase lasts eight core cycles.
- Data changes only in the middle of a low phase.
- Start and stop conditions come only after the slave has released the line, following a stop or an acknowledge phase.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;
    localparam int unsigned NREG    = 8;
    localparam int unsigned DW      = 8;
    localparam int unsigned AW      = $clog2(NREG);
    localparam int unsigned STRAP_W = 4;
    localparam logic [DW-1:0] ID_BYTE = 8'h18;

    typedef enum logic [2:0] {
        PH_IDLE, PH_RX, PH_RXACK, PH_TX, PH_TXACK, PH_WAIT
    } phase_e;

    typedef enum logic [1:0] {K_ADDR, K_CMD, K_COUNT, K_DATA} kind_e;

    typedef struct packed {
        logic       byte_mode;
        logic [1:0] csel;
        logic [4:0] offset;
    } cmd_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    function automatic logic [DW-1:0] reg_default(input int unsigned idx);
        return (idx < 2) ? {DW{1'b1}} : {DW{1'b0}};
    endfunction

    function automatic logic [AW:0] ptr_step(input logic [AW:0] p);
        return (p == (AW+1)'(NREG)) ? p : p + 1'b1;
    endfunction
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync
    import smb_cfg_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_r, sda_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_r <= '1;
            sda_r <= '1;
        end else begin
            scl_r <= {scl_r[DEPTH-2:0], scl_i};
            sda_r <= {sda_r[DEPTH-2:0], sda_i};
        end
    end

    logic scl_s, scl_p, sda_s, sda_p;
    assign scl_s = scl_r[STAGES-1];
    assign scl_p = scl_r[STAGES];
    assign sda_s = sda_r[STAGES-1];
    assign sda_p = sda_r[STAGES];

    always_comb begin
        ev.start = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop  = scl_s & scl_p & ~sda_p & sda_s;
        ev.rise  = ~scl_p & scl_s;
        ev.fall  = scl_p & ~scl_s;
        ev.sda   = sda_s;
    end
endmodule

// File: rtl/smb_reg_file.sv
module smb_reg_file
    import smb_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [DW-1:0]      wr_data,
    input  logic [AW:0]        rd_idx,
    output logic [DW-1:0]      rd_data,
    output logic [NREG*DW-1:0] regs_o
);
    logic [STRAP_W-1:0]        strap_q;
    logic [NREG-1:0][DW-1:0]   view;

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_i;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == NREG - 1) begin : g_id
            assign view[g] = ID_BYTE;
        end else if (g == NREG - 2) begin : g_stat
            logic [DW-STRAP_W-1:0] hi;
            always_ff @(posedge clk) begin
                if (rst) hi <= '0;
                else if (wr_en && wr_idx == AW'(g)) hi <= wr_data[DW-1:STRAP_W];
            end
            assign view[g] = {hi, strap_q};
        end else begin : g_rw
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst) q <= reg_default(g);
                else if (wr_en && wr_idx == AW'(g)) q <= wr_data;
            end
            assign view[g] = q;
        end
    end

    assign regs_o  = view;
    assign rd_data = (rd_idx < (AW+1)'(NREG)) ? view[rd_idx[AW-1:0]] : {DW{1'b1}};
endmodule

// File: rtl/smb_proto.sv
module smb_proto
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h69
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [DW-1:0] rd_data,
    output logic [AW:0]   rd_idx,
    output logic          sda_oe,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    phase_e        phase;
    kind_e         kind;
    logic [2:0]    bitcnt;
    logic          full;
    logic [DW-1:0] sh;
    logic [AW:0]   ptr;
    logic          byte_mode, go_tx, tx_first, macked;

    cmd_t          cmd;
    logic          cmd_ok, addr_hit, load_tx;
    logic [DW-1:0] tx_byte;

    always_comb begin
        cmd      = cmd_t'(sh);
        addr_hit = (sh[7:1] == SLAVE_ADDR);
        cmd_ok   = (cmd.csel == 2'b00) &&
                   (cmd.byte_mode ? (cmd.offset < 5'(NREG)) : (cmd.offset == 5'd0));
        tx_byte  = tx_first ? DW'(NREG) : rd_data;
        load_tx  = ev.fall && ((phase == PH_RXACK && go_tx) ||
                               (phase == PH_TXACK && macked));
    end

    assign rd_idx = ptr;

    always_ff @(posedge clk) begin
        wr_en <= 1'b0;
        if (rst) begin
            phase     <= PH_IDLE;
            kind      <= K_ADDR;
            bitcnt    <= '0;
            full      <= 1'b0;
            sh        <= '0;
            ptr       <= '0;
            byte_mode <= 1'b1;
            go_tx     <= 1'b0;
            tx_first  <= 1'b0;
            macked    <= 1'b0;
            sda_oe    <= 1'b0;
            wr_idx    <= '0;
            wr_data   <= '0;
        end else if (ev.start) begin
            phase  <= PH_RX;
            kind   <= K_ADDR;
            bitcnt <= '0;
            full   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            phase  <= PH_IDLE;
            sda_oe <= 1'b0;
        end else if (load_tx) begin
            phase  <= PH_TX;
            sh     <= tx_byte;
            sda_oe <= ~tx_byte[DW-1];
            bitcnt <= '0;
            if (tx_first) tx_first <= 1'b0;
            else          ptr      <= ptr_step(ptr);
        end else begin
            case (phase)
                PH_RX: begin
                    if (ev.rise) begin
                        sh     <= {sh[DW-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                        full   <= (bitcnt == 3'd7);
                    end else if (ev.fall && full) begin
                        full  <= 1'b0;
                        go_tx <= 1'b0;
                        phase <= PH_RXACK;
                        sda_oe <= 1'b1;
                        case (kind)
                            K_ADDR: begin
                                if (!addr_hit) begin
                                    phase  <= PH_WAIT;
                                    sda_oe <= 1'b0;
                                end else if (sh[0]) begin
                                    go_tx    <= 1'b1;
                                    tx_first <= ~byte_mode;
                                end else begin
                                    kind <= K_CMD;
                                end
                            end
                            K_CMD: begin
                                if (!cmd_ok) begin
                                    phase  <= PH_WAIT;
                                    sda_oe <= 1'b0;
                                end else begin
                                    byte_mode <= cmd.byte_mode;
                                    ptr  <= cmd.byte_mode ? (AW+1)'(cmd.offset) : '0;
                                    kind <= cmd.byte_mode ? K_DATA : K_COUNT;
                                end
                            end
                            K_COUNT: kind <= K_DATA;
                            default: begin
                                if (ptr < (AW+1)'(NREG)) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= ptr[AW-1:0];
                                    wr_data <= sh;
                                end
                                ptr <= byte_mode ? (AW+1)'(NREG) : ptr_step(ptr);
                            end
                        endcase
                    end
                end
                PH_RXACK: begin
                    if (ev.fall) begin
                        sda_oe <= 1'b0;
                        phase  <= PH_RX;
                        bitcnt <= '0;
                    end
                end
                PH_TX: begin
                    if (ev.fall) begin
                        if (bitcnt == 3'd7) begin
                            phase  <= PH_TXACK;
                            sda_oe <= 1'b0;
                        end else begin
                            sh     <= {sh[DW-2:0], 1'b0};
                            sda_oe <= ~sh[DW-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                end
                PH_TXACK: begin
                    if (ev.rise) macked <= ~ev.sda;
                    else if (ev.fall) phase <= PH_WAIT;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
    import smb_cfg_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = 7'h69,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe,
    input  logic [STRAP_W-1:0]  strap_i,
    output logic [NREG*DW-1:0]  regs_o
);
    bus_ev_t       ev;
    logic          start_ev, stop_ev;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [DW-1:0] wr_data, rd_data;
    logic [AW:0]   rd_idx;

    assign start_ev = ev.start;
    assign stop_ev  = ev.stop;

    smb_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    smb_proto #(.SLAVE_ADDR(SLAVE_ADDR)) proto_i (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data), .rd_idx(rd_idx),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    smb_reg_file regs_i (
        .clk(clk), .rst(rst), .strap_i(strap_i), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .rd_idx(rd_idx),
        .rd_data(rd_data), .regs_o(regs_o)
    );
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk
    import smb_cfg_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               scl_i,
    input logic               sda_oe,
    input logic               start_ev,
    input logic               stop_ev,
    input logic               wr_en,
    input logic [NREG*DW-1:0] regs_o
);
    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_i) else $error("sda_oe changed with scl high"); // R4

    AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
        stop_ev |=> !sda_oe) else $error("sda held after stop"); // R10

    AST_RELEASE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe) else $error("sda held after start"); // R1

    AST_REGS_CHANGE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(regs_o)) |-> $past(wr_en))
        else $error("register changed without write"); // R3

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(regs_o[(NREG-2)*DW +: STRAP_W]))
        else $error("strap bits moved"); // R9
endmodule

bind smb_cfg_slave smb_cfg_slave_chk chk_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
    .start_ev(start_ev), .stop_ev(stop_ev), .wr_en(wr_en), .regs_o(regs_o)
);

// File: tb/smb_cfg_slave_tb_top.sv
module smb_cfg_slave_tb_top;
    localparam int Q = 8;
    localparam logic [3:0] STRAP = 4'hA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic [63:0] regs_o;
    wire line = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    smb_cfg_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(line), .sda_oe(sda_oe),
        .strap_i(STRAP), .regs_o(regs_o)
    );

    // offset, write data, expected read value
    localparam logic [18:0] VEC [6] = '{
        {3'd0, 8'h5A, 8'h5A},
        {3'd1, 8'hA5, 8'hA5},
        {3'd2, 8'h3C, 8'h3C},
        {3'd5, 8'h81, 8'h81},
        {3'd6, 8'hF3, 8'hFA},
        {3'd7, 8'h00, 8'h18}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hold(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; hold(); scl = 1'b1; hold(); m_sda = 1'b0; hold(); scl = 1'b0; hold();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hold(); scl = 1'b1; hold(); m_sda = 1'b1; hold(); hold();
    endtask

    task automatic bus_bit(input logic b, output logic r);
        m_sda = b; hold(); scl = 1'b1; hold(); r = line; hold(); scl = 1'b0; hold();
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], r);
        bus_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rbyte(input logic m_ack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, r);
            d[i] = r;
        end
        bus_bit(~m_ack, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] d;
        logic r;
        logic [63:0] snap;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R8 R11 reset values", regs_o, {8'h18, 4'h0, STRAP, 32'h0, 16'hFFFF});

        // table walk: byte write then byte read
        for (int k = 0; k < 6; k++) begin
            logic [2:0] off;
            logic [7:0] wd, ex;
            {off, wd, ex} = VEC[k];
            bus_start(); wbyte(8'hD2, a0); wbyte({3'b100, 2'b00, off}, a1); wbyte(wd, a2); bus_stop();
            check("R3 byte write acks", {a0, a1, a2}, 3'b111);
            bus_start(); wbyte(8'hD2, a0); wbyte({3'b100, 2'b00, off}, a1);
            bus_start(); wbyte(8'hD3, a2); rbyte(1'b0, d); bus_stop();
            check("R4 R9 byte read value", d, ex);
            check("R11 regs_o slice", regs_o[off*8 +: 8], ex);
        end

        snap = regs_o;
        bus_start(); wbyte(8'hA4, a0); wbyte(8'h80, a1); wbyte(8'h77, a2); bus_stop();
        check("R1 foreign address nack", a0, 1'b0);
        check("R1 foreign address no effect", regs_o, snap);

        bus_start(); wbyte(8'hD2, a0); wbyte(8'hA0, a1); wbyte(8'h77, a2); bus_stop();
        check("R2 chip select nack", {a0, a1}, 2'b10);
        check("R2 chip select no effect", regs_o, snap);

        bus_start(); wbyte(8'hD2, a0); wbyte(8'h03, a1); wbyte(8'h02, a2); bus_stop();
        check("R2 block offset nack", a1, 1'b0);
        bus_start(); wbyte(8'hD2, a0); wbyte(8'h88, a1); wbyte(8'h55, a2); bus_stop();
        check("R2 byte offset 8 nack", a1, 1'b0);
        check("R2 rejected commands no effect", regs_o, snap);

        // short block write stopped after three data bytes
        bus_start(); wbyte(8'hD2, a0); wbyte(8'h00, a1); wbyte(8'h03, a2);
        check("R5 block header acks", {a0, a1, a2}, 3'b111);
        wbyte(8'h11, a0); wbyte(8'h22, a1); wbyte(8'h33, a2); bus_stop();
        check("R5 block data acks", {a0, a1, a2}, 3'b111);
        check("R5 short block regs", regs_o, {snap[63:24], 24'h332211});

        // block write running past the last register
        bus_start(); wbyte(8'hD2, a0); wbyte(8'h00, a1); wbyte(8'h0A, a2);
        for (int i = 0; i < 10; i++) begin
            wbyte(8'hB0 + 8'(i), a0);
            if (i >= 8) check("R6 overflow byte acked", a0, 1'b1);
        end
        bus_stop();
        check("R5 R6 R9 long block regs", regs_o, {8'h18, 8'hBA, 48'hB5B4B3B2B1B0});

        // block read: count, eight registers, one past the end
        bus_start(); wbyte(8'hD2, a0); wbyte(8'h00, a1);
        bus_start(); wbyte(8'hD3, a2);
        rbyte(1'b1, d);
        check("R7 block count", d, 8'h08);
        for (int i = 0; i < 8; i++) begin
            rbyte(1'b1, d);
            check("R7 block read data", d, regs_o[i*8 +: 8]);
        end
        rbyte(1'b0, d);
        check("R7 read past end", d, 8'hFF);
        bus_bit(1'b1, r);
        check("R10 line released after nack", r, 1'b1);
        bus_stop();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule